// File: doc/BRIEF.md
# Read Completion Reorder Buffer

This block sits between a DMA read requester and a packet link. Each read request the requester issues is given a tag from a pool of eight, and every tag owns one storage slot sized for one fixed-length request. Completions come back from the link in any order, possibly cut into several beats and interleaved across tags. Each beat is written into the slot named by its tag. Downstream data leaves strictly in the order the reads were issued, so a consumer sees the buffer contents in their sequential order.

A separate saturating counter limits posted write requests to eight in flight. The requester raises a done strobe for each finished write, and the counter frees one credit per strobe.

The drain side is a two-state machine. In `DR_HOLD` the head slot (the oldest outstanding tag) has not yet seen its last beat. The transition *head complete* moves it to `DR_STREAM`, where it presents the slot's beats one by one. The transition *final beat accepted* frees the tag, advances the head to the next tag and returns to `DR_HOLD`. Reset enters `DR_HOLD` with head and issue pointers at tag 0.

Top module: `rd_cpl_reorder`

## Requirements
- R1: After reset, `rd_req_ready` and `wr_req_ready` are 1, `rd_req_tag` is 0, and `out_valid` and `cpl_err` are 0.
- R2: Read tags are handed out in round-robin order 0,1,…,7,0,…; `rd_req_tag` shows the tag the next accepted request will take.
- R3: At most eight reads are outstanding. `rd_req_ready` is 0 exactly while all eight tags are live, and a request offered then is not taken.
- R4: Each accepted completion beat is stored in the slot of its tag at the next free position of that slot, whatever the tag order and interleaving.
- R5: Output data follows request issue order, and within a request it follows beat arrival order.
- R6: `out_valid` is raised for a request only after that request's beat flagged `cpl_last` has arrived.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged.
- R8: A tag becomes free for reissue once its final beat has been accepted downstream (`out_valid` and `out_ready` both 1), and not before.
- R9: A completion beat whose tag is not live, or whose slot has already seen its last beat, is dropped without reaching the output and sets `cpl_err`, which stays 1 until reset.
- R10: At most eight writes are outstanding. `wr_req_ready` is 0 exactly while the write count is 8, and each `wr_req_done` pulse lowers the count by one.
- R11: A `wr_req_done` pulse while no write is outstanding has no effect on the write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Requester offers a read request |
| rd_req_ready | output | 1 | A tag is free, so the request is accepted |
| rd_req_tag | output | 3 | Tag the next accepted read takes |
| wr_req_valid | input | 1 | Requester offers a write request |
| wr_req_ready | output | 1 | Write credit available |
| wr_req_done | input | 1 | One outstanding write has finished |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | 3 | Tag of the completion beat |
| cpl_data | input | 32 | Completion beat payload |
| cpl_last | input | 1 | Final beat of this tag's completion |
| out_valid | output | 1 | In-order data beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | In-order data beat |
| cpl_err | output | 1 | Sticky flag for a dropped completion |

## Verification
Completions are returned in reverse tag order as whole bursts, then split into single beats and interleaved across all eight tags while the pool is full. The first pattern separates tag-indexed storage from storage in arrival order. The second exposes per-slot fill positions that get mixed up and a full-pool stall that leaks a request. Separate runs with the downstream always ready, toggling, blocked and irregular show whether drain and free follow the handshake or only the passing of cycles. Stray beats aimed at an idle tag and at an already completed slot, a burst of 24 reads that wraps the tag pool, and write credits pushed past both bounds cover dropping, reuse and counter saturation.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef enum logic [0:0] {
        DR_HOLD   = 1'b0,
        DR_STREAM = 1'b1
    } drain_state_t;

endpackage

// File: rtl/rcr_tag_alloc.sv
module rcr_tag_alloc #(
    parameter int NUM_TAGS = 8,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    output logic [TAG_W-1:0]    req_tag,
    output logic                alloc_fire,
    output logic [NUM_TAGS-1:0] busy,
    input  logic                free_valid,
    input  logic [TAG_W-1:0]    free_tag
);

    logic [TAG_W-1:0] tail_q;

    assign req_tag    = tail_q;
    assign req_ready  = !busy[tail_q];
    assign alloc_fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
            busy   <= '0;
        end else begin
            if (free_valid) begin
                busy[free_tag] <= 1'b0;
            end
            if (alloc_fire) begin
                busy[tail_q] <= 1'b1;
                tail_q       <= tail_q + 1'b1;
            end
        end
    end

    AST_FULL_POOL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy) == NUM_TAGS) |-> !req_ready); // R3

    AST_TAG_ROUND_ROBIN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> (req_tag == TAG_W'($past(req_tag) + 1'b1))); // R2

endmodule

// File: rtl/rcr_slot_store.sv
module rcr_slot_store #(
    parameter int NUM_TAGS = 8,
    parameter int BEATS    = 4,
    parameter int DATA_W   = 32,
    localparam int TAG_W  = $clog2(NUM_TAGS),
    localparam int BEAT_W = $clog2(BEATS),
    localparam int DEPTH  = NUM_TAGS * BEATS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAGS-1:0] busy,
    input  logic                alloc_fire,
    input  logic [TAG_W-1:0]    alloc_tag,
    input  logic                free_valid,
    input  logic [TAG_W-1:0]    free_tag,
    input  logic                cpl_valid,
    input  logic [TAG_W-1:0]    cpl_tag,
    input  logic [DATA_W-1:0]   cpl_data,
    input  logic                cpl_last,
    input  logic [TAG_W-1:0]    rd_tag,
    input  logic [BEAT_W-1:0]   rd_beat,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_TAGS-1:0] slot_done,
    output logic                cpl_err
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [BEAT_W-1:0] fill_q [NUM_TAGS];
    logic              cpl_ok;
    logic              cpl_bad;

    assign cpl_ok  = cpl_valid && busy[cpl_tag] && !slot_done[cpl_tag];
    assign cpl_bad = cpl_valid && !cpl_ok;
    assign rd_data = mem[{rd_tag, rd_beat}];

    always_ff @(posedge clk) begin
        if (cpl_ok) begin
            mem[{cpl_tag, fill_q[cpl_tag]}] <= cpl_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_done <= '0;
            cpl_err   <= 1'b0;
            for (int i = 0; i < NUM_TAGS; i++) begin
                fill_q[i] <= '0;
            end
        end else begin
            if (alloc_fire) begin
                slot_done[alloc_tag] <= 1'b0;
                fill_q[alloc_tag]    <= '0;
            end
            if (free_valid) begin
                slot_done[free_tag] <= 1'b0;
            end
            if (cpl_ok) begin
                fill_q[cpl_tag] <= fill_q[cpl_tag] + 1'b1;
                if (cpl_last) begin
                    slot_done[cpl_tag] <= 1'b1;
                end
            end
            if (cpl_bad) begin
                cpl_err <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_err |=> cpl_err); // R9

    AST_STRAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !busy[cpl_tag]) |=> cpl_err); // R9

    AST_LAST_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_ok && cpl_last) |=> slot_done[$past(cpl_tag)]); // R4

endmodule

// File: rtl/rcr_drain_fsm.sv
module rcr_drain_fsm
    import rcr_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int BEATS    = 4,
    localparam int TAG_W  = $clog2(NUM_TAGS),
    localparam int BEAT_W = $clog2(BEATS),
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAGS-1:0] slot_done,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [TAG_W-1:0]    head_tag,
    output logic [BEAT_W-1:0]   beat_idx,
    output logic                free_valid,
    output logic [TAG_W-1:0]    free_tag
);

    drain_state_t      state_q, state_d;
    logic [TAG_W-1:0]  head_q;
    logic [BEAT_W-1:0] beat_q;
    logic              take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_HOLD: begin
                if (slot_done[head_q]) begin
                    state_d = DR_STREAM;
                end
            end
            DR_STREAM: begin
                if (out_ready && (beat_q == LAST_BEAT)) begin
                    state_d = DR_HOLD;
                end
            end
        endcase
    end

    always_comb begin
        out_valid  = (state_q == DR_STREAM);
        take       = out_valid && out_ready;
        free_valid = take && (beat_q == LAST_BEAT);
        free_tag   = head_q;
        head_tag   = head_q;
        beat_idx   = beat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_HOLD;
            head_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                beat_q <= beat_q + 1'b1;
            end
            if (free_valid) begin
                head_q <= head_q + 1'b1;
            end
        end
    end

    AST_STREAM_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> slot_done[head_tag]); // R6

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(head_tag) && $stable(beat_idx))); // R7

endmodule

// File: rtl/rcr_wr_credit.sv
module rcr_wr_credit #(
    parameter int MAX_WR = 8,
    localparam int CNT_W = $clog2(MAX_WR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    output logic wr_ready,
    input  logic wr_done
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WR);

    logic [CNT_W-1:0] cnt_q;
    logic             inc;
    logic             dec;

    assign wr_ready = (cnt_q != CAP);
    assign inc      = wr_valid && wr_ready;
    assign dec      = wr_done && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_WR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CAP && !wr_done) |=> (cnt_q == CAP)); // R10

    AST_WR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_valid) |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/rd_cpl_reorder.sv
module rd_cpl_reorder #(
    parameter int NUM_TAGS = 8,
    parameter int BEATS    = 4,
    parameter int DATA_W   = 32,
    parameter int MAX_WR   = 8,
    localparam int TAG_W  = $clog2(NUM_TAGS),
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_valid,
    output logic              rd_req_ready,
    output logic [TAG_W-1:0]  rd_req_tag,
    input  logic              wr_req_valid,
    output logic              wr_req_ready,
    input  logic              wr_req_done,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic              cpl_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              cpl_err
);

    logic                alloc_fire;
    logic [NUM_TAGS-1:0] busy;
    logic [NUM_TAGS-1:0] slot_done;
    logic                free_valid;
    logic [TAG_W-1:0]    free_tag;
    logic [TAG_W-1:0]    head_tag;
    logic [BEAT_W-1:0]   beat_idx;

    rcr_tag_alloc #(.NUM_TAGS(NUM_TAGS)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_tag    (rd_req_tag),
        .alloc_fire (alloc_fire),
        .busy       (busy),
        .free_valid (free_valid),
        .free_tag   (free_tag)
    );

    rcr_slot_store #(
        .NUM_TAGS (NUM_TAGS),
        .BEATS    (BEATS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .alloc_fire (alloc_fire),
        .alloc_tag  (rd_req_tag),
        .free_valid (free_valid),
        .free_tag   (free_tag),
        .cpl_valid  (cpl_valid),
        .cpl_tag    (cpl_tag),
        .cpl_data   (cpl_data),
        .cpl_last   (cpl_last),
        .rd_tag     (head_tag),
        .rd_beat    (beat_idx),
        .rd_data    (out_data),
        .slot_done  (slot_done),
        .cpl_err    (cpl_err)
    );

    rcr_drain_fsm #(
        .NUM_TAGS (NUM_TAGS),
        .BEATS    (BEATS)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_done  (slot_done),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .head_tag   (head_tag),
        .beat_idx   (beat_idx),
        .free_valid (free_valid),
        .free_tag   (free_tag)
    );

    rcr_wr_credit #(.MAX_WR(MAX_WR)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_req_valid),
        .wr_ready (wr_req_ready),
        .wr_done  (wr_req_done)
    );

    AST_FREE_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> busy[free_tag]); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R7

endmodule

// File: tb/rd_cpl_reorder_tb.sv
`timescale 1ns/1ps
module rd_cpl_reorder_tb;

    localparam int NT = 8;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req_valid = 1'b0;
    logic          rd_req_ready;
    logic [2:0]    rd_req_tag;
    logic          wr_req_valid = 1'b0;
    logic          wr_req_ready;
    logic          wr_req_done = 1'b0;
    logic          cpl_valid = 1'b0;
    logic [2:0]    cpl_tag = '0;
    logic [DW-1:0] cpl_data = '0;
    logic          cpl_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          cpl_err;

    always #2.5 clk = ~clk;

    rd_cpl_reorder #(.NUM_TAGS(NT), .BEATS(NB), .DATA_W(DW), .MAX_WR(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_tag   (rd_req_tag),
        .wr_req_valid (wr_req_valid),
        .wr_req_ready (wr_req_ready),
        .wr_req_done  (wr_req_done),
        .cpl_valid    (cpl_valid),
        .cpl_tag      (cpl_tag),
        .cpl_data     (cpl_data),
        .cpl_last     (cpl_last),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .cpl_err      (cpl_err)
    );

    int vectors = 0;
    int fails = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    logic [DW-1:0] exp_q[$];
    bit  m_busy[NT];
    bit  m_done[NT];
    int  m_head = 0;
    int  m_beat = 0;
    int  m_iss  = 0;
    int  m_cnt  = 0;
    int  m_wcnt = 0;
    bit  m_err  = 0;
    bit  prev_stall = 0;
    int  rdy_mode = 0;
    int  rdy_ctr = 0;
    int  d_seq = 0;

    function automatic logic [DW-1:0] dval(input int s, input int b);
        return 32'hA500_0000 ^ DW'(s << 8) ^ DW'(b);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int sum_exp_seq(input int k);
        return k;
    endfunction

    // monitor: compares DUT against the model each cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && started && !finished) begin
            int h;
            h = m_head % NT;
            chk(!out_valid || (m_busy[h] && m_done[h]), "R6", 64'(out_valid), 64'(0));
            if (out_valid && exp_q.size() > 0)
                chk(out_data == exp_q[0], "R4 R5", 64'(out_data), 64'(exp_q[0]));
            else if (out_valid)
                chk(1'b0, "R5", 64'(out_data), 64'(0));
            if (prev_stall)
                chk(out_valid == 1'b1, "R7", 64'(out_valid), 64'(1));
            chk(rd_req_ready == (m_cnt < NT), "R3 R8", 64'(rd_req_ready), 64'(m_cnt < NT));
            chk(rd_req_tag == 3'(m_iss % NT), "R2", 64'(rd_req_tag), 64'(m_iss % NT));
            chk(wr_req_ready == (m_wcnt < 8), "R10 R11", 64'(wr_req_ready), 64'(m_wcnt < 8));
            chk(cpl_err == m_err, "R9", 64'(cpl_err), 64'(m_err));
            prev_stall = out_valid && !out_ready;

            // completions first, on pre-edge state
            if (cpl_valid) begin
                if (m_busy[cpl_tag] && !m_done[cpl_tag]) begin
                    if (cpl_last) m_done[cpl_tag] = 1;
                end else begin
                    m_err = 1;
                end
            end
            // downstream acceptance and tag release (R8)
            if (out_valid && out_ready) begin
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                m_beat++;
                if (m_beat == NB) begin
                    m_busy[h] = 0;
                    m_done[h] = 0;
                    m_cnt--;
                    m_head++;
                    m_beat = 0;
                end
            end
            // issue
            if (rd_req_valid && rd_req_ready) begin
                m_busy[m_iss % NT] = 1;
                m_done[m_iss % NT] = 0;
                for (int b = 0; b < NB; b++) exp_q.push_back(dval(m_iss, b));
                m_iss++;
                m_cnt++;
            end
            // write credits
            begin
                bit inc, dec;
                inc = wr_req_valid && (m_wcnt < 8);
                dec = wr_req_done && (m_wcnt > 0);
                m_wcnt = m_wcnt + int'(inc) - int'(dec);
            end
        end
    end

    // downstream ready patterns
    always @(posedge clk) begin
        #1;
        rdy_ctr++;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = rdy_ctr[0];
            2: out_ready = 1'b0;
            default: out_ready = ((rdy_ctr * 7) % 5) < 3;
        endcase
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue_rd();
        while (!rd_req_ready) tick();
        rd_req_valid = 1'b1;
        tick();
        rd_req_valid = 1'b0;
        d_seq++;
    endtask

    task automatic beat(input int tag, input int seq, input int b, input bit last);
        cpl_valid = 1'b1;
        cpl_tag   = 3'(tag);
        cpl_data  = dval(seq, b);
        cpl_last  = last;
        tick();
        cpl_valid = 1'b0;
        cpl_last  = 1'b0;
    endtask

    task automatic full_cpl(input int seq);
        for (int b = 0; b < NB; b++) beat(seq % NT, seq, b, b == NB - 1);
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            tick();
            n++;
        end
        tick();
        if (exp_q.size() != 0) chk(1'b0, "R5 drain", 64'(exp_q.size()), 64'(0));
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        #0;
        // R1: reset state, seen one step after release, before any edge acts
        chk(rd_req_ready == 1'b1, "R1", 64'(rd_req_ready), 64'(1));
        chk(wr_req_ready == 1'b1, "R1", 64'(wr_req_ready), 64'(1));
        chk(rd_req_tag == 3'd0, "R1", 64'(rd_req_tag), 64'(0));
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'(0));
        chk(cpl_err == 1'b0, "R1", 64'(cpl_err), 64'(0));
        started = 1;
        tick();

        // A: four reads, completions as whole bursts in reverse order
        rdy_mode = 0;
        for (int k = 0; k < 4; k++) issue_rd();
        for (int k = 3; k >= 0; k--) full_cpl(k);
        wait_drain();

        // B: fill the pool, offer a ninth, interleave beat by beat (R3, R4)
        rdy_mode = 1;
        for (int k = 0; k < 8; k++) issue_rd();
        rd_req_valid = 1'b1;
        repeat (3) tick();
        rd_req_valid = 1'b0;
        begin
            int ord[8] = '{6, 2, 7, 0, 4, 3, 5, 1};
            for (int b = 0; b < NB; b++)
                for (int i = 0; i < 8; i++) begin
                    int s;
                    s = 4 + ((ord[i] - 4 + 8) % 8);
                    beat(ord[i], s, b, b == NB - 1);
                end
        end
        wait_drain();

        // C: stray beats to a completed slot and an idle tag (R9), blocked output (R7)
        rdy_mode = 2;
        issue_rd();
        issue_rd();
        full_cpl(d_seq - 2);
        repeat (4) tick();
        beat((d_seq - 2) % NT, 99, 0, 1'b0);
        beat((d_seq + 2) % NT, 98, 0, 1'b1);
        repeat (2) tick();
        rdy_mode = 0;
        full_cpl(d_seq - 1);
        wait_drain();

        // D: write credits past both bounds (R10, R11)
        wr_req_valid = 1'b1;
        repeat (10) tick();
        wr_req_valid = 1'b0;
        wr_req_done = 1'b1;
        repeat (11) tick();
        wr_req_valid = 1'b1;
        repeat (3) tick();
        wr_req_valid = 1'b0;
        wr_req_done = 1'b0;
        repeat (2) tick();

        // E: 24 reads wrapping the tag pool, irregular downstream
        rdy_mode = 3;
        for (int g = 0; g < 6; g++) begin
            int base;
            base = d_seq;
            for (int k = 0; k < 4; k++) issue_rd();
            full_cpl(base + 2);
            full_cpl(base + 0);
            for (int b = 0; b < NB; b++) begin
                beat((base + 3) % NT, base + 3, b, b == NB - 1);
                beat((base + 1) % NT, base + 1, b, b == NB - 1);
            end
        end
        wait_drain();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule